// File: doc/BRIEF.md
# Time-Coded Neighbourhood Cell Evaluator

This block is one processing element of a single-instruction, many-data pixel array. It keeps an 8-bit input value and an 8-bit state value. While a shared digital ramp runs through a program cycle, the cell turns each of its two values into a one-bit time code by comparing the value with the ramp. It drives both bits out to its eight neighbours and takes in their bits.

On every ramp step the cell builds two 9-bit addresses from its 3x3 neighbourhood. One address uses the input codes and the other uses the state codes. Each address reads one bit from a 512-entry table, and all cells in the array share the two tables. The two bits are merged by the composition logic. A saturating counter integrates the merged bit over the sweep, and the last step of the sweep writes the count into the state register. The next sweep then encodes that new state.

The ramp value and the step, first and last markers come from a sequencer that the whole array shares. The two table images also arrive as ports from a store outside the cell.

Top module: `scnn_cell`

## Requirements
- R1: A time-coded bit (`u_bit_o` for the input value, `x_bit_o` for the state value) is 0 while the stored value is strictly greater than `ramp_i`, and 1 otherwise. Both bits are combinational in the ramp.
- R2: `in_we_i` loads `in_data_i` into the input register, and `st_we_i` presets the state register from `st_data_i`. Each takes effect at the clock edge.
- R3: Each address is row-major over the 3x3 neighbourhood. Bit 8 is the top-left neighbour and bit 0 is the bottom-right neighbour. Bit 4 is the cell's own code. Neighbour vector index 7..4 maps to address bits 8..5, and index 3..0 maps to address bits 3..0.
- R4: A neighbour whose `edge_mask_i` bit is 0 contributes a constant 0 to both addresses, whatever it drives.
- R5: The input-code address selects bit `g_table_i[addr]`, and the state-code address selects bit `f_table_i[addr]`.
- R6: With the default composition, the merged bit is the logical AND of the two table bits.
- R7: On a step (`step_i` high) the counter adds the merged bit. A step marked `first_i` starts from zero. Cycles with `step_i` low change nothing.
- R8: The counter saturates at 255 and never wraps. A 256-step sweep whose merged bit is always 1 yields 255.
- R9: The step marked `last_i` writes the final count into the state register, and `state_o` shows it from the next cycle. At other times the state holds unless it is preset.
- R10: After reset the input, state and counter are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we_i | input | 1 | Input register write enable |
| in_data_i | input | 8 | Input value to load |
| st_we_i | input | 1 | State preset enable |
| st_data_i | input | 8 | State preset value |
| ramp_i | input | 8 | Shared ramp value |
| step_i | input | 1 | Ramp step valid |
| first_i | input | 1 | First step of the sweep |
| last_i | input | 1 | Last step of the sweep |
| nbr_u_i | input | 8 | Neighbour input codes, index 7 = top-left ... 0 = bottom-right |
| nbr_x_i | input | 8 | Neighbour state codes, same ordering |
| edge_mask_i | input | 8 | 1 = neighbour exists, same ordering |
| g_table_i | input | 512 | Shared input-code table |
| f_table_i | input | 512 | Shared state-code table |
| u_bit_o | output | 1 | Own input time code |
| x_bit_o | output | 1 | Own state time code |
| state_o | output | 8 | State register |

## Verification
The sweep check begins with both tables all ones, which must saturate at 255, and with the state table cleared, which separates AND from OR. A one-hot input table at the top-left address has exactly one far corner whose code is always 1, so it tells the specified bit order apart from a mirrored one. The same pattern with that neighbour masked tells masking apart from pass-through. Random tables and random values run in chained sweeps with idle cycles carrying junk markers, which exercises state feedback, the clear on the first step and the freezing of the counter while no step is valid.

// File: rtl/scnn_pkg.sv
package scnn_pkg;
  typedef enum logic [1:0] {
    COMP_AND = 2'd0,
    COMP_OR  = 2'd1,
    COMP_XOR = 2'd2
  } comp_e;

  localparam int NBR_CNT = 8;
endpackage

// File: rtl/scnn_tcode.sv
module scnn_tcode #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] value_i,
  input  logic [VW-1:0] ramp_i,
  output logic          bit_o
);
  // low while the value is above the ramp, high once the ramp reaches it
  always_comb begin
    bit_o = (value_i > ramp_i) ? 1'b0 : 1'b1;
  end
endmodule

// File: rtl/scnn_nbhd_addr.sv
module scnn_nbhd_addr #(
  parameter int ABITS = 9
) (
  input  logic             own_i,
  input  logic [ABITS-2:0] nbr_i,
  input  logic [ABITS-2:0] present_i,
  output logic [ABITS-1:0] addr_o
);
  localparam int CTR = ABITS / 2;

  logic [ABITS-2:0] masked;
  assign masked = nbr_i & present_i;

  // row-major: neighbours below the centre keep their index, above shift by one
  for (genvar i = 0; i < ABITS; i++) begin : g_bit
    if (i == CTR) begin : g_ctr
      assign addr_o[i] = own_i;
    end else if (i > CTR) begin : g_hi
      assign addr_o[i] = masked[i-1];
    end else begin : g_lo
      assign addr_o[i] = masked[i];
    end
  end
endmodule

// File: rtl/scnn_lut.sv
module scnn_lut #(
  parameter int ABITS = 9
) (
  input  logic [(1<<ABITS)-1:0] table_i,
  input  logic [ABITS-1:0]      addr_i,
  output logic                  bit_o
);
  always_comb begin
    bit_o = table_i[addr_i];
  end
endmodule

// File: rtl/scnn_integrator.sv
module scnn_integrator #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic          bit_i,
  input  logic          preset_we_i,
  input  logic [CW-1:0] preset_i,
  output logic [CW-1:0] state_o
);
  logic [CW-1:0] acc_q, acc_d, base;
  logic [CW-1:0] state_q, state_d;
  logic [CW:0]   sum;
  logic          acc_en, state_en, commit;

  always_comb begin
    base     = first_i ? '0 : acc_q;
    sum      = {1'b0, base} + {{CW{1'b0}}, bit_i};
    acc_d    = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
    acc_en   = step_i;
    commit   = step_i && last_i;
    state_en = commit || preset_we_i;
    state_d  = commit ? acc_d : preset_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // R7: no step, no change
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(acc_q));
  // R7: first step restarts from zero
  a_r7_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && first_i) |=> (acc_q <= {{(CW-1){1'b0}}, 1'b1}));
  // R8: full counter stays full
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !first_i && (acc_q == {CW{1'b1}})) |=> (acc_q == {CW{1'b1}}));
  // R9: state moves only on commit or preset
  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(step_i && last_i) && !preset_we_i) |=> $stable(state_q));
endmodule

// File: rtl/scnn_cell.sv
module scnn_cell #(
  parameter int               VW    = 8,
  parameter int               ABITS = 9,
  parameter scnn_pkg::comp_e  COMP  = scnn_pkg::COMP_AND
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_we_i,
  input  logic [VW-1:0]         in_data_i,
  input  logic                  st_we_i,
  input  logic [VW-1:0]         st_data_i,
  input  logic [VW-1:0]         ramp_i,
  input  logic                  step_i,
  input  logic                  first_i,
  input  logic                  last_i,
  input  logic [ABITS-2:0]      nbr_u_i,
  input  logic [ABITS-2:0]      nbr_x_i,
  input  logic [ABITS-2:0]      edge_mask_i,
  input  logic [(1<<ABITS)-1:0] g_table_i,
  input  logic [(1<<ABITS)-1:0] f_table_i,
  output logic                  u_bit_o,
  output logic                  x_bit_o,
  output logic [VW-1:0]         state_o
);
  logic [VW-1:0]    in_q, in_d;
  logic [ABITS-1:0] addr_u, addr_x;
  logic             g_bit, f_bit, fog;

  always_comb begin
    in_d = in_we_i ? in_data_i : in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
    end else if (in_we_i) begin
      in_q <= in_d;
    end
  end

  scnn_tcode #(.VW(VW)) u_enc_in (.value_i(in_q),    .ramp_i(ramp_i), .bit_o(u_bit_o));
  scnn_tcode #(.VW(VW)) u_enc_st (.value_i(state_o), .ramp_i(ramp_i), .bit_o(x_bit_o));

  scnn_nbhd_addr #(.ABITS(ABITS)) u_addr_u (
    .own_i(u_bit_o), .nbr_i(nbr_u_i), .present_i(edge_mask_i), .addr_o(addr_u));
  scnn_nbhd_addr #(.ABITS(ABITS)) u_addr_x (
    .own_i(x_bit_o), .nbr_i(nbr_x_i), .present_i(edge_mask_i), .addr_o(addr_x));

  scnn_lut #(.ABITS(ABITS)) u_lut_g (.table_i(g_table_i), .addr_i(addr_u), .bit_o(g_bit));
  scnn_lut #(.ABITS(ABITS)) u_lut_f (.table_i(f_table_i), .addr_i(addr_x), .bit_o(f_bit));

  if (COMP == scnn_pkg::COMP_OR) begin : g_comp_or
    assign fog = g_bit | f_bit;
  end else if (COMP == scnn_pkg::COMP_XOR) begin : g_comp_xor
    assign fog = g_bit ^ f_bit;
  end else begin : g_comp_and
    assign fog = g_bit & f_bit;
  end

  scnn_integrator #(.CW(VW)) u_integ (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .first_i(first_i), .last_i(last_i),
    .bit_i(fog), .preset_we_i(st_we_i), .preset_i(st_data_i), .state_o(state_o));

  // R4: a missing top-left neighbour never reaches the top address bit
  a_r4_edge_top: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mask_i[ABITS-2] |-> (!addr_u[ABITS-1] && !addr_x[ABITS-1]));
  // R3: the centre address bit follows the cell's own codes
  a_r3_centre: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_u[ABITS/2] == u_bit_o) && (addr_x[ABITS/2] == x_bit_o));
endmodule

// File: tb/scnn_cell_test.sv
module scnn_cell_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_we = 1'b0, st_we = 1'b0;
  logic [7:0]   in_data = '0, st_data = '0, ramp = '0;
  logic         step = 1'b0, first = 1'b0, last = 1'b0;
  logic [7:0]   nbr_u = '0, nbr_x = '0, emask = '1;
  logic [511:0] gt = '0, ft = '0;
  logic         u_bit, x_bit;
  logic [7:0]   state;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  logic commit_seen = 1'b0;

  // bench-side model of the cell and its neighbours
  int in_val = 0, st_val = 0;
  int nu[8], nx[8];

  always #10 clk = ~clk;

  scnn_cell uut (
    .clk(clk), .rst_n(rst_n), .in_we_i(in_we), .in_data_i(in_data),
    .st_we_i(st_we), .st_data_i(st_data), .ramp_i(ramp), .step_i(step),
    .first_i(first), .last_i(last), .nbr_u_i(nbr_u), .nbr_x_i(nbr_x),
    .edge_mask_i(emask), .g_table_i(gt), .f_table_i(ft),
    .u_bit_o(u_bit), .x_bit_o(x_bit), .state_o(state));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit tc(input int v, input int r);
    return (v > r) ? 1'b0 : 1'b1;
  endfunction

  function automatic int mk_addr(input bit own, input logic [7:0] nb, input logic [7:0] m);
    logic [7:0] k;
    k = nb & m;
    return int'({k[7:4], own, k[3:0]});
  endfunction

  // monitor: compare committed state against the scoreboard
  always @(posedge clk) commit_seen <= step && last;
  always @(negedge clk) begin
    if (commit_seen) begin
      if (exp_q.size() == 0) check("R9 unexpected commit", int'(state), -1);
      else check("R9 committed state", int'(state), exp_q.pop_front());
    end
  end

  // driver: one full sweep of 256 steps, optional idle gaps with junk markers
  task automatic run_sweep(input bit gaps);
    int cnt = 0;
    for (int r = 0; r < 256; r++) begin
      bit ob_u, ob_x, gb, fb;
      @(negedge clk);
      ramp = 8'(r); step = 1'b1; first = (r == 0); last = (r == 255);
      for (int i = 0; i < 8; i++) begin
        nbr_u[i] = tc(nu[i], r);
        nbr_x[i] = tc(nx[i], r);
      end
      #1;
      ob_u = tc(in_val, r);
      ob_x = tc(st_val, r);
      check("R1 input code", int'(u_bit), int'(ob_u));
      check("R1 state code", int'(x_bit), int'(ob_x));
      if (r == 128) check("R9 state holds mid-sweep", int'(state), st_val);
      gb = gt[mk_addr(ob_u, nbr_u, emask)];   // R3 R4 R5
      fb = ft[mk_addr(ob_x, nbr_x, emask)];
      if (gb && fb) cnt++;                    // R6 AND, R7 count
      if (gaps && (r % 37 == 5)) begin
        @(negedge clk);
        step = 1'b0; first = 1'b1; last = 1'b1; ramp = ~8'(r);  // R7 ignored
      end
    end
    if (cnt > 255) cnt = 255;                 // R8
    exp_q.push_back(cnt);
    st_val = cnt;
    @(negedge clk);
    step = 1'b0; first = 1'b0; last = 1'b0;
    @(negedge clk);
  endtask

  task automatic rand_tables();
    for (int w = 0; w < 16; w++) begin
      gt[w*32 +: 32] = $urandom;
      ft[w*32 +: 32] = $urandom;
    end
  endtask

  task automatic load_in(input int v);
    @(negedge clk); in_we = 1'b1; in_data = 8'(v);
    @(negedge clk); in_we = 1'b0; in_val = v;
  endtask

  task automatic load_st(input int v);
    @(negedge clk); st_we = 1'b1; st_data = 8'(v);
    @(negedge clk); st_we = 1'b0; st_val = v;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin nu[i] = 0; nx[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 reset state", int'(state), 0);
    check("R10 reset input code at ramp 0", int'(u_bit), 1);

    // R2 and R1 boundary: equal value gives 1, one below gives 0
    load_in(100);
    ramp = 8'd99; #1;  check("R1 input above ramp", int'(u_bit), 0);
    ramp = 8'd100; #1; check("R1 input equal ramp", int'(u_bit), 1);
    load_st(50);
    #1; check("R2 state preset", int'(state), 50);
    ramp = 8'd49; #1; check("R1 state above ramp", int'(x_bit), 0);
    ramp = 8'd50; #1; check("R1 state equal ramp", int'(x_bit), 1);

    // R8 R6: both tables all ones -> saturates at 255
    gt = '1; ft = '1;
    run_sweep(1'b0);

    // R6: state table empty -> AND gives zero
    ft = '0;
    run_sweep(1'b0);

    // R3: only the top-left address is set; far corner always 1
    gt = '0; gt[256] = 1'b1; ft = '1;
    load_in(255);
    for (int i = 0; i < 7; i++) nu[i] = 255;
    nu[7] = 0;
    run_sweep(1'b0);
    check("R3 top-left maps to bit 8", st_val, 255);

    // R4: same pattern with the top-left neighbour absent -> zero
    emask = 8'h7F;
    run_sweep(1'b0);
    check("R4 absent neighbour reads 0", st_val, 0);
    emask = '1;

    // R5 R7 R9: random tables and values, chained state, idle gaps
    for (int k = 0; k < 4; k++) begin
      rand_tables();
      load_in(int'($urandom_range(255)));
      for (int i = 0; i < 8; i++) begin
        nu[i] = int'($urandom_range(255));
        nx[i] = int'($urandom_range(255));
      end
      emask = (k == 2) ? 8'hA5 : 8'hFF;
      run_sweep(k[0]);
    end

    repeat (3) @(negedge clk);
    check("R9 all commits observed", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule